// File: doc/BRIEF.md
# Configuration and Status Register Bank with Debug Monitor Select

This block is a byte-wide addressed register file that holds the chip's configuration and a few status values. A simple bus (address, write data, write enable, read enable, registered read data) reaches every register. Most registers are plain read/write storage. One of them is a per-channel disable mask, where a bit set to 1 turns its channel off. Another is a debug control register.

Five registers are read-only. Two of them are saturating event counters, one for accepted triggers and one for rejected triggers. A third is a sticky status flag register. These three are cleared to zero by any write, and the written byte is thrown away. The remaining two read-only registers show the live state of five pairs of internal status signals.

The debug control register does two jobs. First, it selects which of the five status pairs drives the two monitor pins, and it has an active-low monitor enable that is on after reset. Second, it decodes a two-bit test-mode field into a self-test enable and a play-back enable. In that field, bit 1 is a don't-care whenever bit 0 is clear. With the default parameters the bank holds 66 registers: 5 read-only and 61 writable.

Top module: `cfg_bank`

## Requirements
- R1: After reset every mapped register reads 0x00, `chan_off` is all zeros (every channel enabled), both monitor pins are low and both test-mode enables are low.
- R2: The register map is as follows. The sticky status register is at 0x00. The accepted-trigger counter is at 0x01 and the rejected-trigger counter at 0x02. Live pair A (`{3'b0, sig_a}`) is at 0x03 and live pair B (`{3'b0, sig_b}`) at 0x04. Debug control is at 0x05. The mask registers start at 0x06, and the general registers follow directly after the last mask register. Mask and general registers read back the full byte last written. Debug control keeps bits [5:0] and reads 0 in bits [7:6].
- R3: Asserting `bus_re` makes `bus_rdata` show the addressed value after the next rising edge. `bus_rdata` holds its value while `bus_re` is low. A read and a write to the same address in the same cycle return the value held before the write.
- R4: Reads from addresses above the last general register return 0x00. Writes to those addresses change no register.
- R5: Bit j of mask register k drives `chan_off[8k+j]`.
- R6: Each counter adds 1 per cycle in which its strobe is high, and it saturates at 0xFF.
- R7: Any write to a counter clears it to 0, whatever the data. A clearing write in the same cycle as an increment gives 0.
- R8: The status register ORs `stat_evt` into its bits every cycle. Any write to it clears it to 0, and the clear wins over a same-cycle event.
- R9: Writes to the live pair registers have no effect on what they read.
- R10: With debug bit 2 clear and select code s = debug[5:3] below 5, the pins give `mon_a` = `sig_a[s]` and `mon_b` = `sig_b[s]`, one cycle after the inputs. The pairs are indexed 0 = memory pointer wraps, 1 = derandomizer pointer wraps, 2 = self-test busy/fail, 3 = readout start/end, 4 = derandomizer empty/full.
- R11: Debug bit 2 set, or a select code of 5 to 7, drives both monitor pins low.
- R12: Debug[1:0] = 11 raises `selftest_en`, 01 raises `playback_en`, and any value with bit 0 clear raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Registered read data |
| trig_rx_inc | input | 1 | Accepted-trigger increment strobe |
| trig_rej_inc | input | 1 | Rejected-trigger increment strobe |
| stat_evt | input | 8 | Status event bits, set sticky flags |
| sig_a | input | N_PAIRS | First signal of each monitored pair |
| sig_b | input | N_PAIRS | Second signal of each monitored pair |
| mon_a | output | 1 | Monitor pin A |
| mon_b | output | 1 | Monitor pin B |
| chan_off | output | N_CH | Per-channel disable |
| selftest_en | output | 1 | Memory self-test mode |
| playback_en | output | 1 | Play-back mode |
| cfg_gen | output | N_GEN*8 | General configuration bytes, byte i at bits 8i+7:8i |

## Verification
The bench builds the bank with N_GEN = 4 and a 7-bit address. This places the whole map, including 114 unmapped addresses, inside one sweep over all 128 addresses, both writes and reads. All 64 debug control values are applied, each with several status-pair patterns. This covers every select code, the enable bit and the don't-care test-mode bit. The counters are driven past 255 to reach saturation, and same-cycle clear/increment and read/write collisions are exercised directly.

// File: rtl/cfg_bank_pkg.sv
// Package: fixed register addresses and debug-control field positions.
// Assumes byte-wide registers; mask and general bases are derived in the top.
package cfg_bank_pkg;
    localparam int ADR_STATUS = 0;
    localparam int ADR_RXCNT  = 1;
    localparam int ADR_REJCNT = 2;
    localparam int ADR_LIVE_A = 3;
    localparam int ADR_LIVE_B = 4;
    localparam int ADR_DEBUG  = 5;
    localparam int ADR_MASK0  = 6;

    localparam int DBG_W      = 6;   // stored debug bits
    localparam int DBG_OFF    = 2;   // active-high monitor disable
    localparam int SEL_LSB    = 3;
    localparam int SEL_W      = 3;

    typedef enum logic [1:0] {
        MODE_NONE0    = 2'b00,
        MODE_PLAYBACK = 2'b01,
        MODE_NONE2    = 2'b10,
        MODE_SELFTEST = 2'b11
    } test_mode_e;
endpackage

// File: rtl/cfg_bank_cnt.sv
// Module: saturating event counter with clear-on-write.
// Assumes clr comes from any bus write to the counter's address; clear wins.
module cfg_bank_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    // Count up to all-ones, clear on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (inc && (q != {W{1'b1}}))
            q <= q + 1'b1;
    end
endmodule

// File: rtl/cfg_bank_mon.sv
// Module: monitor pin multiplexer.
// Picks one status pair by code; codes at or above N_PAIRS, or disable, give 0.
// Outputs are registered, so the pins lag the inputs by one cycle.
module cfg_bank_mon #(
    parameter int N_PAIRS = 5,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel,
    input  logic               off,
    input  logic [N_PAIRS-1:0] sig_a,
    input  logic [N_PAIRS-1:0] sig_b,
    output logic               mon_a,
    output logic               mon_b
);
    logic pick_a, pick_b;

    // Decode the select code into the chosen pair.
    always_comb begin
        pick_a = 1'b0;
        pick_b = 1'b0;
        for (int k = 0; k < N_PAIRS; k++) begin
            if (!off && (int'(sel) == k)) begin
                pick_a = sig_a[k];
                pick_b = sig_b[k];
            end
        end
    end

    // Register the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_a <= 1'b0;
            mon_b <= 1'b0;
        end else begin
            mon_a <= pick_a;
            mon_b <= pick_b;
        end
    end
endmodule

// File: rtl/cfg_bank.sv
// Module: configuration/status register bank with debug monitor select.
// Assumes a single-cycle write strobe and registered read data; addresses
// beyond the last general register are unmapped (read 0, writes dropped).
module cfg_bank
    import cfg_bank_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int N_GEN   = 56,
    parameter int N_CH    = 32,
    parameter int N_PAIRS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic               bus_we,
    input  logic               bus_re,
    output logic [7:0]         bus_rdata,
    input  logic               trig_rx_inc,
    input  logic               trig_rej_inc,
    input  logic [7:0]         stat_evt,
    input  logic [N_PAIRS-1:0] sig_a,
    input  logic [N_PAIRS-1:0] sig_b,
    output logic               mon_a,
    output logic               mon_b,
    output logic [N_CH-1:0]    chan_off,
    output logic               selftest_en,
    output logic               playback_en,
    output logic [N_GEN*8-1:0] cfg_gen
);
    localparam int MASK_REGS = N_CH / 8;
    localparam int GEN_BASE  = ADR_MASK0 + MASK_REGS;
    localparam int MAP_END   = GEN_BASE + N_GEN;

    logic [7:0]       status_q;
    logic [7:0]       rx_cnt, rej_cnt;
    logic [DBG_W-1:0] dbg_q;
    logic [7:0]       mask_q [MASK_REGS];
    logic [7:0]       gen_q  [N_GEN];
    logic [7:0]       rd_val;
    logic             wr_status, wr_rx, wr_rej, wr_dbg;
    test_mode_e       mode;

    // Decode writes to the fixed registers.
    always_comb begin
        wr_status = bus_we && (int'(bus_addr) == ADR_STATUS);
        wr_rx     = bus_we && (int'(bus_addr) == ADR_RXCNT);
        wr_rej    = bus_we && (int'(bus_addr) == ADR_REJCNT);
        wr_dbg    = bus_we && (int'(bus_addr) == ADR_DEBUG);
    end

    cfg_bank_cnt #(.W(8)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .clr(wr_rx), .inc(trig_rx_inc), .q(rx_cnt)
    );

    cfg_bank_cnt #(.W(8)) u_rej_cnt (
        .clk(clk), .rst_n(rst_n), .clr(wr_rej), .inc(trig_rej_inc), .q(rej_cnt)
    );

    // Sticky status flags; a write clears them and beats new events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (wr_status)
            status_q <= '0;
        else
            status_q <= status_q | stat_evt;
    end

    // Debug control storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbg_q <= '0;
        else if (wr_dbg)
            dbg_q <= bus_wdata[DBG_W-1:0];
    end

    // Channel mask registers, one byte per eight channels.
    for (genvar k = 0; k < MASK_REGS; k++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[k] <= '0;
            else if (bus_we && (int'(bus_addr) == ADR_MASK0 + k))
                mask_q[k] <= bus_wdata;
        end
        assign chan_off[8*k +: 8] = mask_q[k];
    end

    // General configuration registers.
    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        always_ff @(posedge clk) begin
            if (!rst_n)
                gen_q[g] <= '0;
            else if (bus_we && (int'(bus_addr) == GEN_BASE + g))
                gen_q[g] <= bus_wdata;
        end
        assign cfg_gen[8*g +: 8] = gen_q[g];
    end

    // Test-mode decode: bit 0 enables, bit 1 picks self-test over play-back.
    always_comb begin
        mode        = test_mode_e'(dbg_q[1:0]);
        selftest_en = (mode == MODE_SELFTEST);
        playback_en = (mode == MODE_PLAYBACK);
    end

    cfg_bank_mon #(.N_PAIRS(N_PAIRS), .SEL_W(SEL_W)) u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (dbg_q[SEL_LSB +: SEL_W]),
        .off   (dbg_q[DBG_OFF]),
        .sig_a (sig_a),
        .sig_b (sig_b),
        .mon_a (mon_a),
        .mon_b (mon_b)
    );

    // Read multiplexer over the whole map; unmapped gives zero.
    always_comb begin
        rd_val = 8'h00;
        case (int'(bus_addr))
            ADR_STATUS: rd_val = status_q;
            ADR_RXCNT:  rd_val = rx_cnt;
            ADR_REJCNT: rd_val = rej_cnt;
            ADR_LIVE_A: rd_val = 8'(sig_a);
            ADR_LIVE_B: rd_val = 8'(sig_b);
            ADR_DEBUG:  rd_val = 8'(dbg_q);
            default:    rd_val = 8'h00;
        endcase
        for (int k = 0; k < MASK_REGS; k++)
            if (int'(bus_addr) == ADR_MASK0 + k) rd_val = mask_q[k];
        for (int g = 0; g < N_GEN; g++)
            if (int'(bus_addr) == GEN_BASE + g) rd_val = gen_q[g];
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_re)
            bus_rdata <= rd_val;
    end
endmodule

// File: rtl/cfg_bank_chk.sv
// Module: property checker for cfg_bank, attached with bind below.
// Assumes it sees the top's ports plus the debug register and one counter.
module cfg_bank_chk #(
    parameter int ADDR_W  = 7,
    parameter int N_GEN   = 56,
    parameter int N_CH    = 32,
    parameter int N_PAIRS = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic               bus_re,
    input logic [7:0]         bus_rdata,
    input logic [N_PAIRS-1:0] sig_a,
    input logic [N_PAIRS-1:0] sig_b,
    input logic               mon_a,
    input logic               mon_b,
    input logic               selftest_en,
    input logic               playback_en,
    input logic [5:0]         dbg_q,
    input logic [7:0]         rx_cnt
);
    localparam int MAP_END = 6 + N_CH / 8 + N_GEN;

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    p_unmapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && int'(bus_addr) >= MAP_END) |=> (bus_rdata == 8'h00));

    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == 8'hFF && !(bus_we && int'(bus_addr) == 1)) |=> (rx_cnt == 8'hFF));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(bus_addr) == 1) |=> (rx_cnt == 8'h00));

    p_mon_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_q[2] && int'(dbg_q[5:3]) < N_PAIRS)
            |=> (mon_a == $past(sig_a[dbg_q[5:3]]) && mon_b == $past(sig_b[dbg_q[5:3]])));

    p_mon_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_q[2] || int'(dbg_q[5:3]) >= N_PAIRS) |=> (!mon_a && !mon_b));

    p_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({selftest_en, playback_en}));
endmodule

bind cfg_bank cfg_bank_chk #(
    .ADDR_W(ADDR_W), .N_GEN(N_GEN), .N_CH(N_CH), .N_PAIRS(N_PAIRS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .sig_a(sig_a), .sig_b(sig_b),
    .mon_a(mon_a), .mon_b(mon_b), .selftest_en(selftest_en),
    .playback_en(playback_en), .dbg_q(dbg_q), .rx_cnt(rx_cnt)
);

// File: tb/cfg_bank_bench.sv
`timescale 1ns/1ps
// Bench: full address sweep, all debug values, counter and collision cases.
module cfg_bank_bench;
    localparam int ADDR_W = 7;
    localparam int N_GEN  = 4;
    localparam int N_CH   = 32;
    localparam int NP     = 5;
    localparam int GEN_B  = 10;
    localparam int MAPEND = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0]        bus_rdata;
    logic              trig_rx_inc = 1'b0, trig_rej_inc = 1'b0;
    logic [7:0]        stat_evt = '0;
    logic [NP-1:0]     sig_a = '0, sig_b = '0;
    logic              mon_a, mon_b;
    logic [N_CH-1:0]   chan_off;
    logic              selftest_en, playback_en;
    logic [N_GEN*8-1:0] cfg_gen;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cfg_bank #(.ADDR_W(ADDR_W), .N_GEN(N_GEN), .N_CH(N_CH), .N_PAIRS(NP)) u_cfg_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .trig_rx_inc(trig_rx_inc), .trig_rej_inc(trig_rej_inc), .stat_evt(stat_evt),
        .sig_a(sig_a), .sig_b(sig_b), .mon_a(mon_a), .mon_b(mon_b),
        .chan_off(chan_off), .selftest_en(selftest_en), .playback_en(playback_en),
        .cfg_gen(cfg_gen)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        bus_addr = ADDR_W'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        bus_addr = ADDR_W'(a); bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 8'hFF);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5.0);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 mon_a", mon_a, 0);
        chk("R1 mon_b", mon_b, 0);
        chk("R1 chan_off", chan_off, 0);
        chk("R1 modes", {selftest_en, playback_en}, 0);
        for (int a = 0; a < MAPEND; a++) begin
            rd(a, d);
            chk($sformatf("R1 reg %0d", a), d, 0);
        end

        // R2/R4/R9: sweep writes over all 128 addresses, then read back
        sig_a = 5'h15; sig_b = 5'h0A;
        for (int a = 0; a < 128; a++) wr(a, pat(a));
        for (int a = 0; a < 128; a++) begin
            rd(a, d);
            if (a <= 2)             e = 8'h00;
            else if (a == 3)        e = 8'h15;
            else if (a == 4)        e = 8'h0A;
            else if (a == 5)        e = pat(a) & 8'h3F;
            else if (a < MAPEND)    e = pat(a);
            else                    e = 8'h00;
            if (a == 3 || a == 4)      chk($sformatf("R9 live %0d", a), d, e);
            else if (a >= MAPEND)      chk($sformatf("R4 unmapped %0d", a), d, e);
            else                       chk($sformatf("R2 reg %0d", a), d, e);
        end
        // R5: mask to channel mapping
        chk("R5 chan_off", chan_off, {pat(9), pat(8), pat(7), pat(6)});
        chk("R2 cfg_gen", cfg_gen, {pat(13), pat(12), pat(11), pat(10)});

        // R3: hold without read enable
        rd(6, d);
        bus_addr = 7'd7;
        @(negedge clk);
        chk("R3 hold", bus_rdata, pat(6));

        // R10/R11/R12: all debug values with several pair patterns
        for (int v = 0; v < 64; v++) begin
            wr(5, 8'(v));
            chk($sformatf("R12 selftest %0d", v), selftest_en, (v & 3) == 3);
            chk($sformatf("R12 playback %0d", v), playback_en, (v & 3) == 1);
            for (int p = 0; p < 4; p++) begin
                int s;
                logic ea, eb;
                sig_a = 5'((p * 11 + v) & 31);
                sig_b = 5'((p * 7 + 19 + v * 3) & 31);
                @(negedge clk);
                s = v >> 3;
                if (((v >> 2) & 1) == 1 || s >= NP) begin
                    ea = 0; eb = 0;
                    chk($sformatf("R11 mon %0d/%0d", v, p), {mon_a, mon_b}, {ea, eb});
                end else begin
                    ea = sig_a[s]; eb = sig_b[s];
                    chk($sformatf("R10 mon %0d/%0d", v, p), {mon_a, mon_b}, {ea, eb});
                end
            end
        end

        // R6: counting and saturation
        trig_rej_inc = 1'b1;
        repeat (7) @(negedge clk);
        trig_rej_inc = 1'b0;
        rd(2, d);
        chk("R6 rej count 7", d, 7);
        trig_rx_inc = 1'b1;
        repeat (300) @(negedge clk);
        trig_rx_inc = 1'b0;
        rd(1, d);
        chk("R6 rx saturate", d, 8'hFF);

        // R7: clear with simultaneous increment
        trig_rx_inc = 1'b1;
        wr(1, 8'h5A);
        trig_rx_inc = 1'b0;
        rd(1, d);
        chk("R7 clear beats inc", d, 0);
        wr(2, 8'hFF);
        rd(2, d);
        chk("R7 rej clear", d, 0);

        // R3: read and write collide, old value returned
        trig_rx_inc = 1'b1;
        repeat (3) @(negedge clk);
        trig_rx_inc = 1'b0;
        bus_addr = 7'd1; bus_wdata = 8'h33; bus_we = 1'b1; bus_re = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
        chk("R3 read-during-write", bus_rdata, 3);
        rd(1, d);
        chk("R7 after collide", d, 0);

        // R8: sticky status
        stat_evt = 8'h81;
        @(negedge clk);
        stat_evt = 8'h04;
        @(negedge clk);
        stat_evt = 8'h00;
        rd(0, d);
        chk("R8 sticky", d, 8'h85);
        stat_evt = 8'h10;
        wr(0, 8'hA5);
        stat_evt = 8'h00;
        rd(0, d);
        chk("R8 clear beats event", d, 0);

        // R4: unmapped write did not touch mapped state
        wr(100, 8'hEE);
        rd(10, d);
        chk("R4 no alias", d, pat(10));

        finish_run();
    end
endmodule